// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns the one-bit output of a sigma-delta modulator into signed 16-bit samples. It is a third-order cascaded integrator-comb decimator. Each accepted bit counts as +1 or −1. The decimation ratio is eight times an 8-bit filter word, so one result comes out for every `8·word` accepted bits. A clock enable marks the cycles that carry a modulator bit, and bits on other cycles are not used. The full-precision sum is brought to 16 bits by a shift that depends on the ratio, and then saturated.

Software stages a new filter word through a write port. Words below the legal minimum are raised to that minimum. The staged word becomes active only on a restart strobe, which a user issues on a channel change or a synchronized step. The restart clears all filter state, so the first results after it come from a partly filled window. A settled flag stays low for the first two results after a restart or reset, and is high from the third result onward, when the sinc3 window holds only data taken after the restart.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, `dout` is 0, `dout_valid` is 0, `settled` is 0, and the active word is 69, so the first result appears after exactly 552 accepted bits.
- R2: `dout_valid` pulses for one cycle once every `8·word` accepted bits. A bit is accepted only on a cycle with `mod_en` high and `restart` low, and `mod_bit` has no effect on other cycles.
- R3: Let y be the sum of `h[k]·x[n−1−k]`. Here x is +1 for bit 1 and −1 for bit 0, with x taken as zero before the last restart. h is the cubed boxcar of length `R=8·word`, with taps k = 0 to 3R−3. With L = floor(log2 R) and s = 3L, `dout` is y arithmetically shifted right by s−15 (s ≥ 15) or left by 15−s (s < 15), rounded toward minus infinity.
- R4: A scaled value above 32767 gives 32767, and a scaled value below −32768 gives −32768.
- R5: A write with `cfg_we` stages `cfg_word`. Values 0 to 2 are staged as 3, and values 3 to 255 are staged unchanged.
- R6: A staged word has no effect on the output period or value until the next `restart`. A write in the same cycle as `restart` is not used by that restart. That restart takes the word staged before the cycle.
- R7: `restart` clears all integrator, comb and ratio-counter state. A `mod_en` in the same cycle as `restart` is discarded.
- R8: `settled` is 0 in the cycle after `restart`. It goes to 1 together with the third `dout_valid` after the restart, and it stays 1 until the next restart.
- R9: After a step in the input that is not aligned to an output period, the fourth result after the step fully reflects the new input.
- R10: If the bitstream repeats with a period that divides `8·word`, every settled result equals the scaled average of that pattern. A pattern with a 50% density of ones gives exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Marks a cycle that carries a modulator bit |
| mod_bit | input | 1 | Modulator bit (1 → +1, 0 → −1) |
| cfg_we | input | 1 | Stage `cfg_word` |
| cfg_word | input | 8 | New filter word |
| restart | input | 1 | Synchronize strobe: apply the staged word and clear all state |
| dout | output | 16 | Signed decimated result |
| dout_valid | output | 1 | One-cycle pulse when `dout` is new |
| settled | output | 1 | High once results reflect only post-restart data |

## Verification
The assertions check on every cycle the rules that hold locally in time. Result pulses are never back to back, and each one follows an accepted bit. The staged word always stays within its legal range. The active word changes only at a restart. The settled flag drops after a restart, holds between restarts, and rises only together with a result. The numeric value of each result, the exact spacing between results for each word, the clamping of illegal writes, the effect of a step that is not aligned to a period, and exact cancellation of periodic patterns can only be shown by the bench. It compares the outputs on every cycle with a convolution model in several scenarios.

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int WORD_W   = 8,
  parameter int WORD_MIN = 3,
  parameter int WORD_RST = 69,
  parameter int SUB      = 8,
  parameter int OUT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              mod_bit,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              restart,
  output logic [OUT_W-1:0]  dout,
  output logic              dout_valid,
  output logic              settled
);

  localparam int RMAX = SUB * ((1 << WORD_W) - 1);
  localparam int CW   = $clog2(RMAX + 1);
  localparam int AW   = 3 * CW + 1;
  localparam int FS   = OUT_W - 1;
  localparam logic signed [AW-1:0] HI = AW'(2**FS - 1);
  localparam logic signed [AW-1:0] LO = ~HI;

  logic [WORD_W-1:0] word_pend, word_act, pend_in;
  logic [CW-1:0]     ratio, cnt;
  logic [1:0]        nout;
  logic              last;

  logic signed [AW-1:0] x, i1, i2, i3, i1n, i2n, i3n;
  logic signed [AW-1:0] d1, d2, d3, c1, c2, c3, scaled;
  logic [OUT_W-1:0]     sat;
  int                   lg, sh;

  assign pend_in = (cfg_word < WORD_W'(WORD_MIN)) ? WORD_W'(WORD_MIN) : cfg_word;
  assign ratio   = CW'(SUB) * CW'(word_act);
  assign last    = (cnt == ratio - CW'(1));

  assign x   = mod_bit ? AW'(1) : {AW{1'b1}};
  assign i1n = i1 + x;
  assign i2n = i2 + i1n;
  assign i3n = i3 + i2n;
  assign c1  = i3n - d1;
  assign c2  = c1 - d2;
  assign c3  = c2 - d3;

  always_comb begin
    lg = 0;
    for (int b = 0; b < CW; b++)
      if (ratio[b]) lg = b;
    sh = 3 * lg;
    if (sh >= FS) scaled = c3 >>> (sh - FS);
    else          scaled = c3 <<< (FS - sh);
    if (scaled > HI)      sat = HI[OUT_W-1:0];
    else if (scaled < LO) sat = LO[OUT_W-1:0];
    else                  sat = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_pend  <= WORD_W'(WORD_RST);
      word_act   <= WORD_W'(WORD_RST);
      cnt        <= '0;
      nout       <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d2 <= '0; d3 <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      settled    <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      if (cfg_we) word_pend <= pend_in;
      if (restart) begin
        word_act <= word_pend;
        cnt      <= '0;
        nout     <= '0;
        i1 <= '0; i2 <= '0; i3 <= '0;
        d1 <= '0; d2 <= '0; d3 <= '0;
        settled  <= 1'b0;
      end else if (mod_en) begin
        i1 <= i1n;
        i2 <= i2n;
        i3 <= i3n;
        if (last) begin
          cnt        <= '0;
          d1         <= i3n;
          d2         <= c1;
          d3         <= c2;
          dout       <= sat;
          dout_valid <= 1'b1;
          if (nout != 2'd2) nout <= nout + 2'd1;
          if (nout == 2'd2) settled <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R2: results are at least 8*WORD_MIN accepted bits apart
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);
  // R2: a result follows an accepted bit
  a_r2_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(mod_en && !restart));
  // R5
  a_r5_pend_legal: assert property (@(posedge clk) disable iff (!rst_n)
    word_pend >= WORD_W'(WORD_MIN));
  // R6
  a_r6_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(word_act));
  // R7
  a_r7_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
  // R8
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!settled && !dout_valid));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !restart) |=> settled);
  a_r8_rise_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> dout_valid);

endmodule

// File: tb/sinc3_decim_bench.sv
`timescale 1ns/1ps
module sinc3_decim_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0, mod_bit = 1'b0, cfg_we = 1'b0, restart = 1'b0;
  logic [7:0]  cfg_word = 8'd0;
  logic [15:0] dout;
  logic        dout_valid, settled;

  always #2.5 clk = ~clk;

  sinc3_decim u_sinc3_decim (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .restart(restart),
    .dout(dout), .dout_valid(dout_valid), .settled(settled));

  int checks = 0, failures = 0;
  bit done = 0;

  int m_pend = 69, m_act = 69, m_nout = 0;
  bit m_set = 0;
  int xs[$];
  int hh[];
  int outs = 0;
  int last_d = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void build_h(input int r);
    int b2;
    hh = new[3*r-2];
    for (int k = 0; k < 3*r-2; k++) begin
      hh[k] = 0;
      for (int j = 0; j < r; j++) begin
        int m;
        m = k - j;
        if (m >= 0 && m <= 2*r-2) begin
          b2 = (m + 1 < 2*r - 1 - m) ? m + 1 : 2*r - 1 - m;
          hh[k] += b2;
        end
      end
    end
  endfunction

  function automatic int ref_out();
    longint y = 0;
    int n, r, lg, s;
    n = xs.size();
    for (int k = 0; k < hh.size() && k < n; k++)
      y += longint'(hh[k]) * longint'(xs[n-1-k]);
    r = 8 * m_act;
    lg = 0;
    while ((2 << lg) <= r) lg++;
    s = 3 * lg;
    if (s >= 15) y = y >>> (s - 15);
    else         y = y <<< (15 - s);
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic cyc(input bit en, input bit b, input bit s, input bit w, input int word);
    int nxt_pend;
    bit exp_v;
    int exp_d;
    @(negedge clk);
    mod_en = en; mod_bit = b; restart = s; cfg_we = w; cfg_word = word[7:0];
    @(posedge clk);
    #1;
    exp_v = 0; exp_d = 0;
    nxt_pend = w ? ((word < 3) ? 3 : word) : m_pend;
    if (s) begin
      m_act = m_pend; xs.delete(); m_nout = 0; m_set = 0;
      build_h(8 * m_act);
    end else if (en) begin
      xs.push_back(b ? 1 : -1);
      if (xs.size() % (8 * m_act) == 0) begin
        exp_v = 1; exp_d = ref_out(); m_nout++;
        if (m_nout >= 3) m_set = 1;
      end
    end
    m_pend = nxt_pend;
    check(dout_valid == exp_v, "R2", "dout_valid", dout_valid, exp_v);
    if (exp_v) check($signed(dout) == exp_d, "R3", "dout", $signed(dout), exp_d);
    check(settled == m_set, "R8", "settled", settled, m_set);
    if (dout_valid) begin outs++; last_d = $signed(dout); end
  endtask

  function automatic bit pat_bit(input int pat, input int i);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (i % 2 == 0);
      3: return (i % 4 != 3);
      default: return 1'($urandom_range(0, 1));
    endcase
  endfunction

  task automatic feed(input int n, input int pat, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, pat_bit(pat, i), 1'b0, 1'b0, 0);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'($urandom_range(0, 1)), 1'b0, 1'b0, 0);
    end
  endtask

  task automatic do_restart();
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic do_write(input int word);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, word);
  endtask

  initial begin
    build_h(552);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(dout == 16'd0 && !dout_valid && !settled, "R1", "reset outputs",
          {dout_valid, settled, dout}, 0);

    // R1: default word 69 -> first result after 552 bits
    feed(551, 1, 0);
    check(outs == 0, "R1", "results before 552 bits", outs, 0);
    feed(1, 1, 0);
    check(outs == 1, "R1", "results after 552 bits", outs, 1);
    feed(552 * 2, 1, 0);
    check(last_d == 32767, "R4", "positive saturation", last_d, 32767);

    // R5/R6: write 2 (clamped to 3) but no restart yet: period stays 552
    do_write(2);
    outs = 0;
    feed(552, 4, 0);
    check(outs == 1, "R6", "period before restart", outs, 1);
    do_restart();
    check(!settled, "R8", "settled after restart", settled, 0);
    outs = 0;
    feed(24, 0, 0);
    check(outs == 1, "R5", "clamped word 3 gives 24-bit period", outs, 1);
    feed(48, 0, 0);
    check(last_d == -32768, "R4", "negative saturation", last_d, -32768);
    check(settled == 1'b1, "R8", "settled at third result", settled, 1);

    // R2: gaps between accepted bits, random data
    outs = 0;
    feed(24 * 20, 4, 2);
    check(outs == 20, "R2", "results with gapped enable", outs, 20);
    feed(24 * 100, 4, 0);

    // R6: write in the same cycle as restart is not taken by that restart
    do_write(4);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 0);
    outs = 0;
    feed(32, 1, 0);
    check(outs == 1, "R6", "restart uses word staged before", outs, 1);
    feed(64, 1, 0);
    check(last_d == 32767, "R4", "full scale at word 4", last_d, 32767);

    // R10: periodic patterns at word 4
    do_write(4);
    do_restart();
    feed(32 * 5, 3, 0);
    check(last_d == 16384, "R10", "75% density average", last_d, 16384);
    do_restart();
    feed(32 * 5, 2, 0);
    check(last_d == 0, "R10", "50% density cancels", last_d, 0);

    // R7: enable in restart cycle is discarded
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 0);
    outs = 0;
    feed(31, 1, 0);
    check(outs == 0, "R7", "no result 31 bits after restart", outs, 0);
    feed(1, 1, 0);
    check(outs == 1, "R7", "result at 32 bits after restart", outs, 1);

    // R9: unaligned step from zeros to ones
    feed(32 * 4 - 32, 0, 0);
    while (xs.size() % 32 != 13) feed(1, 0, 0);
    outs = 0;
    while (outs < 4) feed(1, 1, 0);
    check(last_d == 32767, "R9", "fourth result after step", last_d, 32767);

    // R5: maximum word 255
    do_write(255);
    do_restart();
    outs = 0;
    feed(2040 * 3, 4, 0);
    check(outs == 3, "R5", "word 255 period", outs, 3);
    do_write(0);
    do_restart();
    outs = 0;
    feed(24 * 3, 1, 0);
    check(outs == 3, "R5", "write 0 clamped to 3", outs, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule